// File: doc/BRIEF.md
# Dual-Window Memory Board Address Decoder

This block turns the upper bits of a 16-bit memory address into chip selects for a memory board. The board claims two independently placed 8 KB windows. The first window holds eight 1 KB ROM sockets in a row. The second window holds four 1 KB ROM sockets in one of its 4 KB halves and a single 1 KB RAM in the other half. The three unused kilobytes of that second half can be handed back to other boards on the bus.

Every setting comes in on static configuration pins. These pins set the base and enable of each window, a swap that exchanges the two base controls, which half of the second window holds ROM, and where the RAM sits. Further pins release the spare region, select half-size ROMs (each socket answers only its first 512 bytes), and turn on a single wait cycle per access. The select outputs are combinational. The only state is the flag that shapes the wait request. Because every decode boundary is 512-byte aligned, the block takes address bits 15 down to 9 only. There is no data stream, so no valid/ready handshake applies.

Top module: `dual_window_decoder`

## Requirements
- R1: An enabled window claims the 8 KB starting at its base × 2000h, where the base is a 3-bit value. A disabled window claims nothing. If both windows cover the same range, the first window (ROM sockets 0–7) wins.
- R2: In the first window, address base + n×400h up to base + n×400h + 3FFh drives rom_sel bit n, for n from 0 to 7.
- R3: In the second window, ROM sockets 8–11 (rom_sel bits 8–11, 1 KB each, in ascending order) fill the lower 4 KB half when cfg_b_rom_upper is 0 and the upper half when it is 1.
- R4: ram_sel is high for the 1 KB slot at index cfg_ram_slot (0–3, counted from the bottom) inside the half of the second window that does not hold ROM.
- R5: At most one of the thirteen selects (rom_sel bits and ram_sel) is high at any time.
- R6: With cfg_half_rom high, the upper 512 bytes of each 1 KB ROM slot (address bit 9 set) drive no rom_sel bit, yet board_sel stays high there.
- R7: The three spare 1 KB slots of the second window keep board_sel high with no select, unless cfg_release_spare is high. In that case board_sel is low there.
- R8: With cfg_swap high, the first window takes its base and enable from cfg_base_b/cfg_en_b, and the second window takes them from cfg_base_a/cfg_en_a.
- R9: With cfg_wait_en high, wait_req is high in the first clock cycle of each stretch in which board_sel is high, and only in that cycle. board_sel must go low before another request can appear. With cfg_wait_en low, wait_req stays low.
- R10: With the second window at base 6 (C000h), ROM in the lower half, RAM slot 3 and the spare released, C000h–CFFFh selects ROM, DC00h–DFFFh selects RAM, and D000h–DBFFh leaves the board unselected.
- R11: While rst_n is low, wait_req is low, and the wait history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the wait-state flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Address bits 15:9 |
| cfg_base_a | input | 3 | Base control A (address bits 15:13) |
| cfg_en_a | input | 1 | Enable control A |
| cfg_base_b | input | 3 | Base control B |
| cfg_en_b | input | 1 | Enable control B |
| cfg_swap | input | 1 | Exchange controls A and B between the windows |
| cfg_b_rom_upper | input | 1 | Second window ROM in upper half when 1 |
| cfg_ram_slot | input | 2 | RAM slot index in the non-ROM half |
| cfg_release_spare | input | 1 | Release the spare 3 KB |
| cfg_half_rom | input | 1 | Half-size ROM mode |
| cfg_wait_en | input | 1 | Request one wait cycle per access |
| rom_sel | output | 12 | One-hot ROM socket select |
| ram_sel | output | 1 | RAM select |
| board_sel | output | 1 | Board responds to this address |
| wait_req | output | 1 | Wait-cycle request |

## Verification
The bench builds the block with its default widths: a 16-bit space, 8 KB windows and 1 KB slots. With these values the decoder sees only 128 distinct address inputs. The bench therefore sweeps all 128 of them under each configuration it tries, which covers every window edge, every socket boundary and every 512-byte gap. The configurations cover:
- overlapping windows and disabled windows;
- both ROM halves with different RAM slots, with the spare region released and kept;
- half-size ROMs, and swapped controls.

Hand-picked address sequences drive board_sel into and out of the board, and between the two windows without a gap, to expose the wait-request edge.

// File: rtl/dwd_pkg.sv
package dwd_pkg;
  localparam int ADDR_W  = 16;
  localparam int WIN_W   = 13;
  localparam int SLOT_W  = 10;
  localparam int BASE_W  = ADDR_W - WIN_W;
  localparam int SEG_W   = WIN_W - SLOT_W + 1;
  localparam int HI_W    = ADDR_W - SLOT_W + 1;
  localparam int IDX_A_W = WIN_W - SLOT_W;
  localparam int IDX_B_W = IDX_A_W - 1;
  localparam int A_SLOTS = 1 << IDX_A_W;
  localparam int B_SLOTS = 1 << IDX_B_W;
  localparam int SOCKETS = A_SLOTS + B_SLOTS;
  localparam int N_WIN   = 2;

  typedef struct packed {
    logic              en;
    logic [BASE_W-1:0] base;
  } win_cfg_t;
endpackage

// File: rtl/dwd_window_hit.sv
module dwd_window_hit
  import dwd_pkg::*;
(
  input  logic [HI_W-1:0]  addr_hi,
  input  win_cfg_t         cfg,
  output logic             hit,
  output logic [SEG_W-1:0] seg
);
  always_comb begin
    hit = cfg.en && (addr_hi[HI_W-1 -: BASE_W] == cfg.base);
    seg = addr_hi[SEG_W-1:0];
  end
endmodule

// File: rtl/dwd_a_layout.sv
module dwd_a_layout
  import dwd_pkg::*;
(
  input  logic               hit,
  input  logic               half_rom,
  input  logic [SEG_W-1:0]   seg,
  output logic [A_SLOTS-1:0] rom
);
  logic [IDX_A_W-1:0] idx;
  logic               gap;

  always_comb begin
    idx = seg[SEG_W-1:1];
    gap = half_rom && seg[0];
  end

  for (genvar i = 0; i < A_SLOTS; i++) begin : g_sock
    assign rom[i] = hit && !gap && (idx == IDX_A_W'(i));
  end
endmodule

// File: rtl/dwd_b_layout.sv
module dwd_b_layout
  import dwd_pkg::*;
(
  input  logic               hit,
  input  logic               half_rom,
  input  logic               rom_upper,
  input  logic [IDX_B_W-1:0] ram_slot,
  input  logic               release_spare,
  input  logic [SEG_W-1:0]   seg,
  output logic [B_SLOTS-1:0] rom,
  output logic               ram,
  output logic               claim
);
  logic               in_rom_half;
  logic [IDX_B_W-1:0] idx;
  logic               gap;
  logic               spare;

  always_comb begin
    in_rom_half = (seg[SEG_W-1] == rom_upper);
    idx         = seg[SEG_W-2:1];
    gap         = half_rom && seg[0];
    ram         = hit && !in_rom_half && (idx == ram_slot);
    spare       = hit && !in_rom_half && (idx != ram_slot);
    claim       = hit && !(spare && release_spare);
  end

  for (genvar i = 0; i < B_SLOTS; i++) begin : g_sock
    assign rom[i] = hit && in_rom_half && !gap && (idx == IDX_B_W'(i));
  end
endmodule

// File: rtl/dwd_wait_gen.sv
module dwd_wait_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic wait_en,
  output logic wait_req
);
  logic sel_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_d <= 1'b0;
    else        sel_d <= sel;
  end

  assign wait_req = rst_n && wait_en && sel && !sel_d;

  // R9: a request never lasts longer than one clock
  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req |=> !wait_req);
endmodule

// File: rtl/dual_window_decoder.sv
module dual_window_decoder
  import dwd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HI_W-1:0]     bus_addr,
  input  logic [BASE_W-1:0]   cfg_base_a,
  input  logic                cfg_en_a,
  input  logic [BASE_W-1:0]   cfg_base_b,
  input  logic                cfg_en_b,
  input  logic                cfg_swap,
  input  logic                cfg_b_rom_upper,
  input  logic [IDX_B_W-1:0]  cfg_ram_slot,
  input  logic                cfg_release_spare,
  input  logic                cfg_half_rom,
  input  logic                cfg_wait_en,
  output logic [SOCKETS-1:0]  rom_sel,
  output logic                ram_sel,
  output logic                board_sel,
  output logic                wait_req
);
  win_cfg_t             ctl_a, ctl_b;
  win_cfg_t             win_cfg [N_WIN];
  logic [N_WIN-1:0]     win_hit;
  logic [SEG_W-1:0]     win_seg [N_WIN];
  logic                 hit_b_only;
  logic [A_SLOTS-1:0]   rom_a;
  logic [B_SLOTS-1:0]   rom_b;
  logic                 ram_b;
  logic                 claim_b;

  always_comb begin
    ctl_a      = '{en: cfg_en_a, base: cfg_base_a};
    ctl_b      = '{en: cfg_en_b, base: cfg_base_b};
    win_cfg[0] = cfg_swap ? ctl_b : ctl_a;
    win_cfg[1] = cfg_swap ? ctl_a : ctl_b;
  end

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    dwd_window_hit u_hit (
      .addr_hi (bus_addr),
      .cfg     (win_cfg[w]),
      .hit     (win_hit[w]),
      .seg     (win_seg[w])
    );
  end

  assign hit_b_only = win_hit[1] && !win_hit[0];

  dwd_a_layout u_a (
    .hit      (win_hit[0]),
    .half_rom (cfg_half_rom),
    .seg      (win_seg[0]),
    .rom      (rom_a)
  );

  dwd_b_layout u_b (
    .hit           (hit_b_only),
    .half_rom      (cfg_half_rom),
    .rom_upper     (cfg_b_rom_upper),
    .ram_slot      (cfg_ram_slot),
    .release_spare (cfg_release_spare),
    .seg           (win_seg[1]),
    .rom           (rom_b),
    .ram           (ram_b),
    .claim         (claim_b)
  );

  assign rom_sel   = {rom_b, rom_a};
  assign ram_sel   = ram_b;
  assign board_sel = win_hit[0] || claim_b;

  dwd_wait_gen u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (board_sel),
    .wait_en  (cfg_wait_en),
    .wait_req (wait_req)
  );

  // R5: selects are mutually exclusive
  a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, ram_sel}));
  // R7: any chip select implies the board answers
  a_r7_select_claims: assert property (@(posedge clk) disable iff (!rst_n)
    (|{rom_sel, ram_sel}) |-> board_sel);
  // R1: both controls disabled leaves the board silent
  a_r1_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en_a && !cfg_en_b) |-> !board_sel);
  // R6: the upper half of a slot is a gap for ROM in half-size mode
  a_r6_half_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_half_rom && bus_addr[0]) |-> (rom_sel == '0));
  // R9: a wait request only accompanies a board access
  a_r9_wait_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req |-> (board_sel && cfg_wait_en));
endmodule

// File: tb/sim_dual_window_decoder.sv
module sim_dual_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [2:0]  cfg_base_a = '0, cfg_base_b = '0;
  logic        cfg_en_a = 0, cfg_en_b = 0, cfg_swap = 0, cfg_b_rom_upper = 0;
  logic [1:0]  cfg_ram_slot = '0;
  logic        cfg_release_spare = 0, cfg_half_rom = 0, cfg_wait_en = 0;
  logic [11:0] rom_sel;
  logic        ram_sel, board_sel, wait_req;

  always #2 clk = ~clk;

  dual_window_decoder u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .cfg_base_a(cfg_base_a), .cfg_en_a(cfg_en_a),
    .cfg_base_b(cfg_base_b), .cfg_en_b(cfg_en_b),
    .cfg_swap(cfg_swap), .cfg_b_rom_upper(cfg_b_rom_upper),
    .cfg_ram_slot(cfg_ram_slot), .cfg_release_spare(cfg_release_spare),
    .cfg_half_rom(cfg_half_rom), .cfg_wait_en(cfg_wait_en),
    .rom_sel(rom_sel), .ram_sel(ram_sel), .board_sel(board_sel),
    .wait_req(wait_req)
  );

  typedef struct {
    logic [2:0] base_a, base_b;
    logic       en_a, en_b, swap, rom_hi, half, rel, wt;
    logic [1:0] ram;
  } cfg_t;

  typedef struct {
    logic [11:0] rom;
    logic        ram, sel, wt;
    int          addr;
    string       tag;
  } item_t;

  item_t q[$];
  int    compared = 0;
  int    mismatched = 0;
  logic  last_sel = 1'b0;
  bit    done = 0;

  function automatic item_t model(cfg_t c, logic [6:0] a, logic prev);
    item_t e;
    int addr, ea, eb, ba, bb, off, r, ramoff, romlo;
    addr = int'(a) << 9;
    e.rom = '0; e.ram = 0; e.sel = 0; e.addr = addr;
    ea = c.swap ? c.en_b : c.en_a;  ba = int'(c.swap ? c.base_b : c.base_a) * 8192;
    eb = c.swap ? c.en_a : c.en_b;  bb = int'(c.swap ? c.base_a : c.base_b) * 8192;
    if (ea != 0 && addr >= ba && addr < ba + 8192) begin
      off = addr - ba;
      e.sel = 1;
      if (!(c.half && (off % 1024) >= 512)) e.rom[off / 1024] = 1'b1;
    end else if (eb != 0 && addr >= bb && addr < bb + 8192) begin
      off = addr - bb;
      romlo = c.rom_hi ? 4096 : 0;
      ramoff = (c.rom_hi ? 0 : 4096) + int'(c.ram) * 1024;
      if (off >= romlo && off < romlo + 4096) begin
        r = off - romlo;
        e.sel = 1;
        if (!(c.half && (r % 1024) >= 512)) e.rom[8 + r / 1024] = 1'b1;
      end else if (off >= ramoff && off < ramoff + 1024) begin
        e.ram = 1; e.sel = 1;
      end else begin
        e.sel = !c.rel;
      end
    end
    e.wt = c.wt && e.sel && !prev;
    return e;
  endfunction

  task automatic apply(cfg_t c, logic [6:0] a, string tag);
    item_t e;
    @(posedge clk);
    #1;
    cfg_base_a = c.base_a; cfg_base_b = c.base_b; cfg_en_a = c.en_a;
    cfg_en_b = c.en_b; cfg_swap = c.swap; cfg_b_rom_upper = c.rom_hi;
    cfg_ram_slot = c.ram; cfg_release_spare = c.rel; cfg_half_rom = c.half;
    cfg_wait_en = c.wt; bus_addr = a;
    e = model(c, a, last_sel);
    e.tag = tag;
    last_sel = e.sel;
    q.push_back(e);
  endtask

  task automatic sweep(cfg_t c, string tag);
    for (int i = 0; i < 128; i++) apply(c, 7'(i), tag);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      compared++;
      if (rom_sel !== e.rom || ram_sel !== e.ram || board_sel !== e.sel || wait_req !== e.wt) begin
        mismatched++;
        $display("FAIL %s addr=%h: rom=%h ram=%b sel=%b wait=%b expected rom=%h ram=%b sel=%b wait=%b",
                 e.tag, e.addr, rom_sel, ram_sel, board_sel, wait_req, e.rom, e.ram, e.sel, e.wt);
      end
      compared++;
      if ($countones({rom_sel, ram_sel}) > 1) begin
        mismatched++;
        $display("FAIL R5 addr=%h: %0d selects active, expected at most 1",
                 e.addr, $countones({rom_sel, ram_sel}));
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    cfg_t c;
    c = '{base_a: 3'd0, base_b: 3'd0, en_a: 1, en_b: 0, swap: 0, rom_hi: 0,
          half: 0, rel: 0, wt: 1, ram: 2'd0};
    // R11: selected access during reset gives no wait request
    cfg_en_a = 1; cfg_wait_en = 1; bus_addr = 7'd0;
    repeat (3) @(negedge clk);
    compared++;
    if (wait_req !== 1'b0) begin
      mismatched++;
      $display("FAIL R11: wait_req=%b expected 0", wait_req);
    end
    cfg_en_a = 0; cfg_wait_en = 0;
    @(negedge clk);
    rst_n = 1;

    // R1: all disabled
    c.en_a = 0; c.wt = 0;
    sweep(c, "R1");
    // R2: first window at 2000h
    c.en_a = 1; c.base_a = 3'd1;
    sweep(c, "R2");
    // R1: overlapping windows, first window wins
    c.en_b = 1; c.base_b = 3'd1;
    sweep(c, "R1");
    // R3: second window at 4000h, ROM upper, RAM slot 1, spare kept
    c.en_a = 0; c.base_b = 3'd2; c.rom_hi = 1; c.ram = 2'd1;
    sweep(c, "R3");
    // R7: spare released
    c.rel = 1;
    sweep(c, "R7");
    // R4: ROM lower, RAM slot 2
    c.rel = 0; c.rom_hi = 0; c.ram = 2'd2; c.base_b = 3'd5;
    sweep(c, "R4");
    // R10: reference layout
    c.base_b = 3'd6; c.ram = 2'd3; c.rel = 1; c.en_a = 1; c.base_a = 3'd0;
    sweep(c, "R10");
    // R6: half-size ROMs in both windows
    c.half = 1; c.rom_hi = 1; c.ram = 2'd0;
    sweep(c, "R6");
    // R8: swapped controls
    c.half = 0; c.swap = 1; c.base_a = 3'd1; c.base_b = 3'd6; c.en_b = 0; c.en_a = 1;
    sweep(c, "R8");
    c.en_b = 1;
    sweep(c, "R8");

    // R9: wait requests
    c = '{base_a: 3'd1, base_b: 3'd2, en_a: 1, en_b: 1, swap: 0, rom_hi: 0,
          half: 0, rel: 1, wt: 1, ram: 2'd0};
    apply(c, 7'h00, "R9");  // outside
    apply(c, 7'h10, "R9");  // into A: request
    apply(c, 7'h11, "R9");  // stay: none
    apply(c, 7'h12, "R9");
    apply(c, 7'h20, "R9");  // into B without gap: none
    apply(c, 7'h00, "R9");  // leave
    apply(c, 7'h21, "R9");  // back in: request
    apply(c, 7'h2A, "R9");  // released spare: board_sel low
    apply(c, 7'h28, "R9");  // RAM: request again
    c.wt = 0;
    apply(c, 7'h00, "R9");
    apply(c, 7'h10, "R9");  // disabled option: no request
    apply(c, 7'h11, "R9");
    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule